// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Channel

This block is a single memory-to-memory copy channel driven by a chain of transfer descriptors that software places in memory. Each descriptor is four consecutive words. It holds a source address, a destination address and a control word carrying a word count, a ring-wrap flag and a valid flag. Software programs a ring base address and a current-descriptor pointer, then sets the enable bit. From then on the channel needs no further attention until the queue drains.

For each valid descriptor the channel reads all four words. It copies the requested number of words one at a time, reading each word from the source and then writing it to the destination. It then rewrites the control word in memory with the valid flag cleared. Next it moves to the following descriptor, or back to the ring base when the wrap flag was set. When it fetches a descriptor whose valid flag is clear, it drops the enable bit and stops with the pointer left on that descriptor. Software restarts the channel by refilling that descriptor and setting enable again. All memory traffic goes through one word-wide master port with a request/ready handshake.

Top module: `dma_ring_channel`

## Requirements
- R1: After reset the ring base, the current pointer, enable and busy all read as zero, and no memory request is raised.
- R2: Register select 0 is the ring base, select 1 is the current pointer and select 2 is control/status (bit 0 enable, bit 1 busy). All three read back at any time. Writes to selects 0 and 1 are ignored while enable or busy is set.
- R3: Writing 1 to control bit 0 sets enable. The channel then reads the words at pointer, pointer+4, pointer+8 and pointer+12, in that order. The fourth word is discarded.
- R4: Descriptor word 0 is the source address and word 1 is the destination address. Word 2 is the control word: bits [15:0] hold the word count, bit 30 is the wrap flag and bit 31 is the valid flag.
- R5: A valid descriptor with count N makes N read/write pairs. Pair k reads source+4k and then writes that data to destination+4k.
- R6: A count of zero performs no data access, and the write-back follows the fetch directly.
- R7: After the copy, the channel writes only address pointer+8, with bit 31 cleared and every other control bit unchanged.
- R8: After write-back the pointer becomes the ring base if the wrap flag was set, and pointer+16 otherwise.
- R9: Fetching a control word with bit 31 clear clears enable, ends busy, leaves the pointer on that descriptor and writes nothing to memory.
- R10: After software rewrites the descriptor at the pointer and sets enable again, the channel resumes from that pointer.
- R11: A raised request holds address, direction and write data stable until ready is seen. The access completes in the cycle where request and ready are both high, and read data is taken in that cycle.
- R12: Writing 0 to the enable bit while the channel is active has no effect, and the queue still runs to completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
A wrong pointer or sequencer state becomes visible on the memory port at the next access. The fetch addresses, the copy addresses or the write-back address would be off, and the bench memory image would then differ after the ring drains. A wrong captured count or flag shows up as extra, missing or misplaced copied words, or as a control word written back with the wrong bits. These defects appear within one descriptor, a few dozen cycles. An enable bit that fails to clear or clears too early shows at the control register as a stuck busy or a truncated queue. The final pointer readback exposes a wrong wrap decision.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

   localparam int DESC_WORDS = 4;
   localparam int BEAT_W     = $clog2(DESC_WORDS);

   localparam logic [1:0] SEL_BASE = 2'd0;
   localparam logic [1:0] SEL_PTR  = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_FETCH = 3'd1,
      PH_CHECK = 3'd2,
      PH_READ  = 3'd3,
      PH_WRITE = 3'd4,
      PH_WBACK = 3'd5
   } dma_phase_e;

endpackage

// File: rtl/dma_ring_regs.sv
module dma_ring_regs
   import dma_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              ptr_ld,
   input  logic [ADDR_W-1:0] ptr_nxt,
   input  logic              en_clr,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] ptr_q,
   output logic              en_q
);

   logic              locked;
   logic [DATA_W-1:0] rd_next;

   assign locked = busy | en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ptr_q  <= '0;
         en_q   <= 1'b0;
      end else begin
         if (reg_wr && reg_sel == SEL_BASE && !locked)
            base_q <= reg_wdata[ADDR_W-1:0];
         if (ptr_ld)
            ptr_q <= ptr_nxt;
         else if (reg_wr && reg_sel == SEL_PTR && !locked)
            ptr_q <= reg_wdata[ADDR_W-1:0];
         if (en_clr)
            en_q <= 1'b0;
         else if (reg_wr && reg_sel == SEL_CTRL && reg_wdata[0])
            en_q <= 1'b1;
      end
   end

   always_comb begin
      rd_next = '0;
      case (reg_sel)
         SEL_BASE: rd_next = DATA_W'(base_q);
         SEL_PTR:  rd_next = DATA_W'(ptr_q);
         SEL_CTRL: rd_next = DATA_W'({busy, en_q});
         default:  rd_next = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_next;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_next;
      end
   endgenerate

endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
   import dma_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int LAST_BIT  = 30,
   parameter int VALID_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] ptr_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ptr_ld,
   output logic [ADDR_W-1:0] ptr_nxt,
   output logic              en_clr,
   output logic              busy,
   output dma_phase_e        phase
);

   localparam int          WORD_BYTES = DATA_W / 8;
   localparam int          WB_SHIFT   = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(2 * WORD_BYTES);
   localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DESC_WORDS * WORD_BYTES);
   localparam logic [DATA_W-1:0] VMASK    = DATA_W'(1) << VALID_BIT;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DESC_WORDS - 1);

   dma_phase_e        state_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] src_q;
   logic [ADDR_W-1:0] dst_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] fetch_off;

   assign phase     = state_q;
   assign busy      = (state_q != PH_IDLE);
   assign fetch_off = ADDR_W'(beat_q) << WB_SHIFT;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         PH_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = ptr_addr + fetch_off;
         end
         PH_READ: begin
            mem_req  = 1'b1;
            mem_addr = src_q;
         end
         PH_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_wdata = data_q;
         end
         PH_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr_addr + CTRL_OFF;
            mem_wdata = ctrl_q & ~VMASK;
         end
         default: ;
      endcase
   end

   assign ptr_ld  = (state_q == PH_WBACK) && mem_ready;
   assign ptr_nxt = ctrl_q[LAST_BIT] ? base_addr : ptr_addr + STRIDE;
   assign en_clr  = (state_q == PH_CHECK) && !ctrl_q[VALID_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         beat_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         ctrl_q  <= '0;
         cnt_q   <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            PH_IDLE: begin
               beat_q <= '0;
               if (en) state_q <= PH_FETCH;
            end
            PH_FETCH: begin
               if (mem_ready) begin
                  case (beat_q)
                     BEAT_W'(0): src_q <= mem_rdata[ADDR_W-1:0];
                     BEAT_W'(1): dst_q <= mem_rdata[ADDR_W-1:0];
                     BEAT_W'(2): begin
                        ctrl_q <= mem_rdata;
                        cnt_q  <= mem_rdata[CNT_W-1:0];
                     end
                     default: ;
                  endcase
                  if (beat_q == LAST_BEAT) state_q <= PH_CHECK;
                  beat_q <= beat_q + 1'b1;
               end
            end
            PH_CHECK: begin
               if (!ctrl_q[VALID_BIT])  state_q <= PH_IDLE;
               else if (cnt_q == '0)    state_q <= PH_WBACK;
               else                     state_q <= PH_READ;
            end
            PH_READ: begin
               if (mem_ready) begin
                  data_q  <= mem_rdata;
                  state_q <= PH_WRITE;
               end
            end
            PH_WRITE: begin
               if (mem_ready) begin
                  src_q   <= src_q + STEP;
                  dst_q   <= dst_q + STEP;
                  cnt_q   <= cnt_q - 1'b1;
                  state_q <= (cnt_q == CNT_W'(1)) ? PH_WBACK : PH_READ;
               end
            end
            PH_WBACK: begin
               if (mem_ready) begin
                  beat_q  <= '0;
                  state_q <= PH_FETCH;
               end
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_ring_channel.sv
module dma_ring_channel
   import dma_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 16,
   parameter int LAST_BIT  = 30,
   parameter int VALID_BIT = 31,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int WORD_BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_data_w
         $error("DATA_W must be a power-of-two number of bytes");
      end
      if (ADDR_W > DATA_W || ADDR_W < 8) begin : g_bad_addr_w
         $error("ADDR_W must lie between 8 and DATA_W");
      end
      if (VALID_BIT >= DATA_W || LAST_BIT >= DATA_W || VALID_BIT == LAST_BIT) begin : g_bad_flags
         $error("flag bit positions must be distinct and inside the word");
      end
      if (CNT_W < 1 || CNT_W > LAST_BIT || CNT_W > VALID_BIT) begin : g_bad_cnt
         $error("count field must sit below both flag bits");
      end
   endgenerate

   logic              busy_w;
   logic              en_w;
   logic              en_clr_w;
   logic              ptr_ld_w;
   logic [ADDR_W-1:0] ptr_nxt_w;
   logic [ADDR_W-1:0] base_w;
   logic [ADDR_W-1:0] ptr_w;
   dma_phase_e        phase_w;

   dma_ring_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_sel  (reg_sel),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .busy     (busy_w),
      .ptr_ld   (ptr_ld_w),
      .ptr_nxt  (ptr_nxt_w),
      .en_clr   (en_clr_w),
      .base_q   (base_w),
      .ptr_q    (ptr_w),
      .en_q     (en_w)
   );

   dma_ring_seq #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .LAST_BIT (LAST_BIT),
      .VALID_BIT(VALID_BIT)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_w),
      .base_addr(base_w),
      .ptr_addr (ptr_w),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_ready(mem_ready),
      .mem_rdata(mem_rdata),
      .ptr_ld   (ptr_ld_w),
      .ptr_nxt  (ptr_nxt_w),
      .en_clr   (en_clr_w),
      .busy     (busy_w),
      .phase    (phase_w)
   );

endmodule

// File: rtl/dma_ring_chk.sv
module dma_ring_chk
   import dma_ring_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int VALID_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              busy,
   input logic              en,
   input logic [ADDR_W-1:0] ptr,
   input dma_phase_e        phase
);

   localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(2 * (DATA_W / 8));
   localparam logic [ADDR_W-1:0] STRIDE   = ADDR_W'(DESC_WORDS * (DATA_W / 8));

   // R11: request and its payload stay put until accepted
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R1: an idle channel never touches memory
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R3: descriptor fetches are reads inside the current descriptor
   a_r3_fetch_window: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_FETCH |-> mem_req && !mem_we && (mem_addr - ptr) < STRIDE);

   // R7: write-back targets the control word and clears the valid flag
   a_r7_wback_clears: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_WBACK |-> mem_we && !mem_wdata[VALID_BIT] && mem_addr == ptr + CTRL_OFF);

   // R9: pointer moves only by software while the channel is idle
   a_r9_ptr_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !(reg_wr && reg_sel == SEL_PTR) |=> $stable(ptr));

   // R9: enable drops only after a descriptor check
   a_r9_en_fall_check: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> $past(phase) == PH_CHECK);

   // R12: enable survives every active phase except the check
   a_r12_en_kept: assert property (@(posedge clk) disable iff (!rst_n)
      busy && phase != PH_CHECK |=> en);

endmodule

bind dma_ring_channel dma_ring_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .VALID_BIT(VALID_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_sel  (reg_sel),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ready(mem_ready),
   .busy     (busy_w),
   .en       (en_w),
   .ptr      (ptr_w),
   .phase    (phase_w)
);

// File: tb/tb_dma_ring_channel.sv
`timescale 1ns/1ps
module tb_dma_ring_channel;

   localparam logic [31:0] VB = 32'h8000_0000;
   localparam logic [31:0] LB = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we, mem_ready = 1'b1;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   logic [31:0] mem [0:1023];
   logic [31:0] exp_m [0:1023];
   logic [31:0] log_addr [0:63];
   logic [31:0] log_data [0:63];
   logic        log_we [0:63];
   int          log_n = 0;
   bit          stall_en = 1'b0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   dma_ring_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata));

   function automatic logic [9:0] widx(input logic [31:0] a);
      return a[11:2];
   endfunction

   assign mem_rdata = mem[widx(mem_addr)];

   initial forever begin
      @(posedge clk);
      if (mem_req && mem_ready) begin
         if (mem_we) mem[widx(mem_addr)] <= mem_wdata;
         if (log_n < 64) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
            log_we[log_n]   = mem_we;
            log_n++;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      mem_ready <= stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [31:0] d);
      @(negedge clk);
      reg_sel = s;
      #1 d = reg_rdata;
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] v);
      mem[widx(a)] = v;
      exp_m[widx(a)] = v;
   endtask

   task automatic fill_random();
      for (int i = 0; i < 1024; i++) begin
         mem[i] = $urandom;
         exp_m[i] = mem[i];
      end
   endtask

   // reference walk of the ring over the expected image
   task automatic model(input logic [31:0] base, inout logic [31:0] p);
      logic [31:0] c, s, d;
      for (int g = 0; g < 64; g++) begin
         c = exp_m[widx(p + 8)];
         if (!c[31]) break;
         s = exp_m[widx(p)];
         d = exp_m[widx(p + 4)];
         for (int k = 0; k < int'(c[15:0]); k++)
            exp_m[widx(d + 32'(4 * k))] = exp_m[widx(s + 32'(4 * k))];
         exp_m[widx(p + 8)] = c & ~VB;
         p = c[30] ? base : p + 32'd16;
      end
   endtask

   task automatic wait_idle();
      logic [31:0] st;
      st = 32'd1;
      while (st[1:0] != 2'b00) rd_reg(2'd2, st);
   endtask

   task automatic compare_mem(input string tag);
      int bad;
      bad = 0;
      for (int i = 0; i < 1024; i++) begin
         n_chk++;
         if (mem[i] !== exp_m[i]) begin
            n_fail++;
            if (bad < 4)
               $display("FAIL %s word@%h actual=%h expected=%h", tag, i * 4, mem[i], exp_m[i]);
            bad++;
         end
      end
   endtask

   task automatic finish_run(input logic [31:0] exp_ptr, input string tag);
      logic [31:0] r;
      wait_idle();
      compare_mem(tag);
      rd_reg(2'd1, r);
      check(r == exp_ptr, "R8/R9 final pointer", r, exp_ptr);
      rd_reg(2'd2, r);
      check(r == 32'd0, "R9 enable and busy cleared", r, 32'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r, p, base;
      void'($urandom(32'd20240611));
      fill_random();
      repeat (3) @(negedge clk);
      check(mem_req == 1'b0, "R1 no request in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      rd_reg(2'd0, r); check(r == 0, "R1 base after reset", r, 0);
      rd_reg(2'd1, r); check(r == 0, "R1 pointer after reset", r, 0);
      rd_reg(2'd2, r); check(r == 0, "R1 control after reset", r, 0);
      check(mem_req == 1'b0, "R1 idle memory port", 32'(mem_req), 32'd0);

      // directed ring: count 3, count 0, count 5 with wrap
      put(32'h100, 32'h400); put(32'h104, 32'h800); put(32'h108, VB | 32'd3);
      put(32'h110, 32'h440); put(32'h114, 32'h840); put(32'h118, VB);
      put(32'h840, 32'hDEAD_0000);
      put(32'h120, 32'h480); put(32'h124, 32'h880); put(32'h128, VB | LB | 32'd5);
      wr_reg(2'd0, 32'h100);
      wr_reg(2'd1, 32'h100);
      rd_reg(2'd0, r); check(r == 32'h100, "R2 base readback", r, 32'h100);
      rd_reg(2'd1, r); check(r == 32'h100, "R2 pointer readback", r, 32'h100);
      base = 32'h100; p = 32'h100;
      model(base, p);
      log_n = 0;
      wr_reg(2'd2, 32'd1);
      rd_reg(2'd2, r); check(r[0] == 1'b1, "R3 enable set", r, 32'd1);
      wr_reg(2'd0, 32'hABC0);
      wr_reg(2'd1, 32'hDEF0);
      wr_reg(2'd2, 32'd0);
      rd_reg(2'd2, r); check(r[0] == 1'b1, "R12 enable not cleared by write of 0", r, 32'd1);
      finish_run(p, "R5/R8/R12 directed ring");
      rd_reg(2'd0, r); check(r == 32'h100, "R2 base write ignored while active", r, 32'h100);
      for (int i = 0; i < 4; i++)
         check(!log_we[i] && log_addr[i] == 32'h100 + 32'(4 * i), "R3 fetch order", log_addr[i], 32'h100 + 32'(4 * i));
      for (int k = 0; k < 3; k++) begin
         check(!log_we[4 + 2 * k] && log_addr[4 + 2 * k] == 32'h400 + 32'(4 * k), "R4/R5 source read", log_addr[4 + 2 * k], 32'h400 + 32'(4 * k));
         check(log_we[5 + 2 * k] && log_addr[5 + 2 * k] == 32'h800 + 32'(4 * k), "R4/R5 destination write", log_addr[5 + 2 * k], 32'h800 + 32'(4 * k));
      end
      check(log_we[10] && log_addr[10] == 32'h108, "R7 write-back address", log_addr[10], 32'h108);
      check(log_data[10] == 32'd3, "R7 write-back data", log_data[10], 32'd3);
      check(log_addr[11] == 32'h110 && !log_we[11], "R8 sequential next descriptor", log_addr[11], 32'h110);
      check(log_we[15] && log_addr[15] == 32'h118, "R6 zero count goes to write-back", log_addr[15], 32'h118);
      check(log_data[15] == 32'd0, "R6 zero count write-back data", log_data[15], 32'd0);

      // restart from the pointer after refilling the descriptor
      put(32'h108, VB | 32'h0123_0002);
      p = 32'h100;
      model(base, p);
      wr_reg(2'd2, 32'd1);
      finish_run(p, "R10 restart");

      // enabling on an empty descriptor changes nothing
      p = 32'h110;
      wr_reg(2'd2, 32'd1);
      finish_run(p, "R9 empty queue");

      // randomized rings under memory stalls
      for (int run = 0; run < 10; run++) begin
         int nd, cnt;
         logic [31:0] c;
         stall_en = run[0];
         fill_random();
         nd = $urandom_range(1, 4);
         base = 32'h40 * $urandom_range(0, 3);
         for (int i = 0; i < nd; i++) begin
            cnt = $urandom_range(0, 8);
            c = {($urandom_range(0, 4) != 0), (i == nd - 1), 14'($urandom), 16'(cnt)};
            put(base + 32'(16 * i), 32'h400 + 32'(64 * i));
            put(base + 32'(16 * i) + 4, 32'h800 + 32'(64 * i));
            put(base + 32'(16 * i) + 8, c);
         end
         p = base + 32'(16 * $urandom_range(0, nd - 1));
         wr_reg(2'd0, base);
         wr_reg(2'd1, p);
         model(base, p);
         wr_reg(2'd2, 32'd1);
         finish_run(p, "R11 random ring image");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule